// File: doc/BRIEF.md
# Output-Compare PWM Waveform Generator

This block produces a pulse-width-modulated output from one free-running counter and one compare register. It has no period counter. A prescaler turns a tick-enable input into counter steps. On every step where the counter equals the compare register, the output pin takes a level that was preset before the match. The scheduler then inverts the preset level and moves the compare register forward by the on delay or the off delay. The next edge is therefore placed relative to the previous compare point, not relative to a counter wrap.

The integrator drives two delay values, in counter ticks, and a start strobe. The start strobe arms the scheduler. It presets the high level and places the first match one off delay after the counter value it sees. The delay inputs may change at any time. A new value applies only from the next reschedule onwards.

Top module: `ocp_pwm_gen`

## Requirements
- R1: The counter advances once for every PRE_DIV clock cycles in which `tick_en` is high (PRE_DIV defaults to 8). Cycles with `tick_en` low neither advance the counter nor the prescaler phase, so they lengthen the running segment one-for-one.
- R2: The counter is CNT_W bits (default 16), runs freely, wraps modulo 2^CNT_W and is never reloaded by a match or a start.
- R3: After reset, `pwm_o` is 0 and `match_o` stays 0 until the first start strobe.
- R4: A start strobe presets the next level to high and loads the compare register with the current counter value plus `off_dly_i`. The first match after it drives `pwm_o` high, between off×PRE_DIV and off×PRE_DIV+PRE_DIV−1 clocks after the start edge.
- R5: `pwm_o` changes only at a match, and then takes the preset level.
- R6: A match that drives the output high presets low and adds `on_dly_i` to the compare register. A match that drives it low presets high and adds `off_dly_i`. Consecutive matches are therefore delay×PRE_DIV clocks apart while `tick_en` stays high.
- R7: The reschedule adds the delay to the low DLY_W bits of the compare value and passes the carry into the upper bits. The result is a sum modulo 2^CNT_W.
- R8: The delay inputs are sampled only in the cycle of a reschedule. A change during a segment leaves that segment's length unchanged and applies from the next reschedule.
- R9: `match_o` is a one-clock pulse, registered in the same edge that updates `pwm_o`. It follows a step in which the armed counter equalled the compare register.
- R10: With PRE_DIV=8 and both delays at 125, each half-period is 1000 clocks. This is a 50% square wave at one two-thousandth of the clock rate.
- R11: A start strobe while running restarts the schedule as in R4. If a start and a match fall in the same cycle, the start wins and the output holds its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Enables the prescaler in this cycle |
| start_i | input | 1 | Start strobe; arms and restarts the schedule |
| on_dly_i | input | DLY_W | High-segment length in counter ticks |
| off_dly_i | input | DLY_W | Low-segment length in counter ticks |
| pwm_o | output | 1 | PWM output |
| match_o | output | 1 | One-clock pulse on each compare match |

## Verification
The hardest case to reach from the ports is a delay change that lands inside a running segment. The old value must still time that segment and the new one the segment after it. The stimulus reaches this by synchronising on the observed match pulse and then changing the delays. A similar sync gates `tick_en` in the middle of a known segment and restarts the generator while it runs. The expected interval sequence on both sides of each change follows from the requirements.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_e;

    localparam int unsigned DEF_PRE_DIV = 8;
    localparam int unsigned DEF_CNT_W   = 16;
    localparam int unsigned DEF_DLY_W   = 8;
endpackage

// File: rtl/ocp_prescale.sv
module ocp_prescale #(
    parameter int unsigned PRE_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    output logic step_o
);
    generate
        if (PRE_DIV <= 1) begin : g_pass
            assign step_o = tick_en;
        end else begin : g_div
            localparam int unsigned PW = $clog2(PRE_DIV);
            localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);

            typedef struct packed {
                logic [PW-1:0] phase;
            } pre_t;

            pre_t pre_d, pre_q;

            always_comb begin
                pre_d = pre_q;
                if (tick_en) begin
                    if (pre_q.phase == LAST) pre_d.phase = '0;
                    else                     pre_d.phase = pre_q.phase + 1'b1;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pre_q <= '0;
                else        pre_q <= pre_d;
            end

            assign step_o = tick_en && (pre_q.phase == LAST);
        end
    endgenerate
endmodule

// File: rtl/ocp_freerun.sv
module ocp_freerun #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    output logic [CNT_W-1:0] cnt_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } fr_t;

    fr_t fr_d, fr_q;

    always_comb begin
        fr_d = fr_q;
        if (step_i) fr_d.cnt = fr_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fr_q <= '0;
        else        fr_q <= fr_d;
    end

    assign cnt_o = fr_q.cnt;
endmodule

// File: rtl/ocp_resched_add.sv
module ocp_resched_add #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned DLY_W = 8
) (
    input  logic [CNT_W-1:0] base_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic [CNT_W-1:0] sum_o
);
    generate
        if (CNT_W > DLY_W) begin : g_split
            localparam int unsigned HW = CNT_W - DLY_W;
            logic [DLY_W-1:0] lo_sum;
            logic             carry;
            logic [HW-1:0]    hi_sum;
            always_comb begin
                {carry, lo_sum} = {1'b0, base_i[DLY_W-1:0]} + {1'b0, dly_i};
                hi_sum          = base_i[CNT_W-1:DLY_W] + HW'(carry);
                sum_o           = {hi_sum, lo_sum};
            end
        end else begin : g_flat
            always_comb sum_o = base_i + dly_i[CNT_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/ocp_sched.sv
module ocp_sched
    import ocp_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             start_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [DLY_W-1:0] on_dly_i,
    input  logic [DLY_W-1:0] off_dly_i,
    output logic             pwm_o,
    output logic             match_o,
    output logic             nxt_lvl_o,
    output logic             armed_o,
    output logic [CNT_W-1:0] cmp_o
);
    typedef struct packed {
        logic             armed;
        lvl_e             nxt_lvl;
        logic             pwm;
        logic             match;
        logic [CNT_W-1:0] cmp;
    } sch_t;

    sch_t sch_d, sch_q;

    logic             hit;
    logic [CNT_W-1:0] add_base;
    logic [DLY_W-1:0] add_dly;
    logic [CNT_W-1:0] add_sum;

    always_comb begin
        hit      = sch_q.armed && step_i && (cnt_i == sch_q.cmp);
        add_base = start_i ? cnt_i : sch_q.cmp;
        if (start_i)                        add_dly = off_dly_i;
        else if (sch_q.nxt_lvl == LVL_HIGH) add_dly = on_dly_i;
        else                                add_dly = off_dly_i;
    end

    ocp_resched_add #(
        .CNT_W (CNT_W),
        .DLY_W (DLY_W)
    ) u_add (
        .base_i (add_base),
        .dly_i  (add_dly),
        .sum_o  (add_sum)
    );

    always_comb begin
        sch_d       = sch_q;
        sch_d.match = 1'b0;
        if (start_i) begin
            sch_d.armed   = 1'b1;
            sch_d.nxt_lvl = LVL_HIGH;
            sch_d.cmp     = add_sum;
        end else if (hit) begin
            sch_d.pwm     = (sch_q.nxt_lvl == LVL_HIGH);
            sch_d.match   = 1'b1;
            sch_d.nxt_lvl = (sch_q.nxt_lvl == LVL_HIGH) ? LVL_LOW : LVL_HIGH;
            sch_d.cmp     = add_sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sch_q.armed   <= 1'b0;
            sch_q.nxt_lvl <= LVL_LOW;
            sch_q.pwm     <= 1'b0;
            sch_q.match   <= 1'b0;
            sch_q.cmp     <= '0;
        end else begin
            sch_q <= sch_d;
        end
    end

    assign pwm_o     = sch_q.pwm;
    assign match_o   = sch_q.match;
    assign nxt_lvl_o = (sch_q.nxt_lvl == LVL_HIGH);
    assign armed_o   = sch_q.armed;
    assign cmp_o     = sch_q.cmp;
endmodule

// File: rtl/ocp_pwm_gen.sv
module ocp_pwm_gen
    import ocp_pkg::*;
#(
    parameter int unsigned PRE_DIV = DEF_PRE_DIV,
    parameter int unsigned CNT_W   = DEF_CNT_W,
    parameter int unsigned DLY_W   = DEF_DLY_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             start_i,
    input  logic [DLY_W-1:0] on_dly_i,
    input  logic [DLY_W-1:0] off_dly_i,
    output logic             pwm_o,
    output logic             match_o
);
    logic             step_w;
    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-1:0] cmp_w;
    logic             nxt_lvl_w;
    logic             armed_w;

    ocp_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .step_o  (step_w)
    );

    ocp_freerun #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step_w),
        .cnt_o  (cnt_w)
    );

    ocp_sched #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_sch (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (step_w),
        .start_i   (start_i),
        .cnt_i     (cnt_w),
        .on_dly_i  (on_dly_i),
        .off_dly_i (off_dly_i),
        .pwm_o     (pwm_o),
        .match_o   (match_o),
        .nxt_lvl_o (nxt_lvl_w),
        .armed_o   (armed_w),
        .cmp_o     (cmp_w)
    );
endmodule

// File: rtl/ocp_pwm_gen_chk.sv
module ocp_pwm_gen_chk #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned DLY_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             step_w,
    input logic             start_i,
    input logic [CNT_W-1:0] cnt_w,
    input logic [CNT_W-1:0] cmp_w,
    input logic             nxt_lvl_w,
    input logic             armed_w,
    input logic             pwm_o,
    input logic             match_o,
    input logic [DLY_W-1:0] on_dly_i,
    input logic [DLY_W-1:0] off_dly_i
);
    p_step_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        step_w |=> cnt_w == CNT_W'($past(cnt_w) + 1'b1));

    p_idle_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_w |-> (!pwm_o && !match_o));

    p_start_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (armed_w && nxt_lvl_w &&
                     cmp_w == CNT_W'($past(cnt_w) + CNT_W'($past(off_dly_i)))));

    p_level_taken_r5: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> pwm_o == $past(nxt_lvl_w));

    p_edge_only_at_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_o != $past(pwm_o)) |-> match_o);

    p_level_flips_r6: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> nxt_lvl_w != pwm_o);

    p_resched_sum_r7: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> cmp_w == CNT_W'($past(cmp_w) +
            CNT_W'($past(nxt_lvl_w) ? $past(on_dly_i) : $past(off_dly_i))));

    p_match_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> ($past(step_w) && $past(armed_w) && !$past(start_i) &&
                     $past(cnt_w) == $past(cmp_w)));
endmodule

bind ocp_pwm_gen ocp_pwm_gen_chk #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_w    (step_w),
    .start_i   (start_i),
    .cnt_w     (cnt_w),
    .cmp_w     (cmp_w),
    .nxt_lvl_w (nxt_lvl_w),
    .armed_w   (armed_w),
    .pwm_o     (pwm_o),
    .match_o   (match_o),
    .on_dly_i  (on_dly_i),
    .off_dly_i (off_dly_i)
);

// File: tb/tb_ocp_pwm_gen.sv
module tb_ocp_pwm_gen;
    localparam int DIV = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b1;
    logic       start_i = 1'b0;
    logic [7:0] on_dly_i = 8'd0;
    logic [7:0] off_dly_i = 8'd0;
    logic       pwm_o;
    logic       match_o;

    always #2 clk = ~clk;

    ocp_pwm_gen dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .start_i   (start_i),
        .on_dly_i  (on_dly_i),
        .off_dly_i (off_dly_i),
        .pwm_o     (pwm_o),
        .match_o   (match_o)
    );

    typedef struct {
        bit    lvl;
        int    lo;
        int    hi;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    int   cyc = 0;
    int   last_cyc = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic void push(input bit lvl, input int lo, input int hi, input string req);
        exp_t e;
        e.lvl = lvl; e.lo = lo; e.hi = hi; e.req = req;
        exp_q.push_back(e);
    endfunction

    // Monitor: pops one expected item per observed match pulse.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && match_o) begin
                int iv;
                iv = cyc - last_cyc;
                last_cyc = cyc;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected match pulse", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(pwm_o == e.lvl, e.req, "level after match", int'(pwm_o), int'(e.lvl));
                    check(iv >= e.lo && iv <= e.hi, e.req, "match interval", iv, e.lo);
                end
            end
        end
    end

    task automatic pulse_start();
        @(negedge clk);
        start_i  = 1'b1;
        last_cyc = cyc + 1;
        @(negedge clk);
        start_i  = 1'b0;
    endtask

    task automatic drain();
        wait (exp_q.size() == 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(pwm_o == 1'b0, "R3", "pwm in reset", int'(pwm_o), 0);
        check(match_o == 1'b0, "R3", "match in reset", int'(match_o), 0);
        rst_n = 1'b1;

        // R3: idle without start, no pulse and output low
        on_dly_i = 8'd3; off_dly_i = 8'd3;
        repeat (2000) @(negedge clk);
        check(pwm_o == 1'b0, "R3", "pwm idle before start", int'(pwm_o), 0);

        // R4/R6: first run, on=10 off=20
        on_dly_i = 8'd10; off_dly_i = 8'd20;
        pulse_start();
        push(1, 20*DIV, 20*DIV+DIV-1, "R4");
        push(0, 10*DIV, 10*DIV, "R6");
        push(1, 20*DIV, 20*DIV, "R6");
        push(0, 10*DIV, 10*DIV, "R6");
        push(1, 20*DIV, 20*DIV, "R6");
        drain();

        // R8: change delays right after a high-driving match; running segment keeps old on
        on_dly_i = 8'd40; off_dly_i = 8'd5;
        push(0, 10*DIV, 10*DIV, "R8");
        push(1, 5*DIV, 5*DIV, "R8");
        push(0, 40*DIV, 40*DIV, "R8");
        drain();

        // R1: gate tick_en for 50 cycles inside the 5-tick low segment is too short;
        // wait for the next high segment (40 ticks) and gate inside it
        push(1, 5*DIV, 5*DIV, "R1");
        drain();
        repeat (10) @(negedge clk);
        tick_en = 1'b0;
        repeat (50) @(negedge clk);
        tick_en = 1'b1;
        push(0, 40*DIV + 50, 40*DIV + 50, "R1");
        drain();

        // R10 (crosses high-byte carries of the compare, R7): 125/125 square wave
        on_dly_i = 8'd125; off_dly_i = 8'd125;
        push(1, 5*DIV, 5*DIV, "R8");
        push(0, 125*DIV, 125*DIV, "R10 R7");
        for (int i = 0; i < 4; i++) begin
            push(1, 125*DIV, 125*DIV, "R10 R7");
            push(0, 125*DIV, 125*DIV, "R10 R7");
        end
        drain();

        // R11: restart mid-segment (output low now), R2 counter keeps running
        repeat (300) @(negedge clk);
        on_dly_i = 8'd7; off_dly_i = 8'd9;
        pulse_start();
        push(1, 9*DIV, 9*DIV+DIV-1, "R11");
        push(0, 7*DIV, 7*DIV, "R11 R2");
        push(1, 9*DIV, 9*DIV, "R11 R2");
        drain();

        // R9/R5: no pulse and no level change between matches
        repeat (5*DIV - 2) @(negedge clk);
        check(pwm_o == 1'b1, "R5", "level held inside segment", int'(pwm_o), 1);
        push(0, 7*DIV, 7*DIV, "R9");
        drain();
        @(negedge clk);
        check(match_o == 1'b0, "R9", "match is one clock wide", int'(match_o), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d pending expected 0", exp_q.size());
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule